// File: doc/BRIEF.md
# Serial Register Readout Engine

This block streams the contents of a small byte-addressed register file onto a serial line. A start strobe provides a 4-bit start address and a byte count. The engine then fetches one byte at a time through a combinational read port and shifts each byte out bit by bit. The serial clock is produced internally by dividing the system clock.

Three control inputs are captured when a transfer starts:
- **Byte order** sets whether the address steps up or down between bytes.
- **Bit order** sets whether each byte is sent MSB or LSB first.
- **Pin select** chooses between a shared bidirectional data pin and a dedicated output pin.

Each pin has its own output enable. An enable is high only while read bits are being shifted out on that pin, so the pad is released whenever no data is leaving.

The block is placed behind a serial command decoder. That decoder resolves the address and count of a read instruction and hands them over with a single-cycle strobe. Transmitted bits change on the falling edge of the serial clock, so the far end can sample them on the rising edge.

Top module: `serial_reg_reader`

## Requirements
- R1: Out of reset and whenever no transfer is running, `busy_o`, `sclk_o`, `sdio_oe_o` and `sdo_oe_o` are all low.
- R2: With the byte-order input at 0, the first byte sent is read from the start address, and each following byte is read from the next higher address.
- R3: With the byte-order input at 1, the first byte sent is read from the start address, and each following byte is read from the next lower address.
- R4: With the bit-order input at 0, each byte is sent bit 7 first and bit 0 last.
- R5: With the bit-order input at 1, each byte is sent bit 0 first and bit 7 last.
- R6: With the pin-select input at 0, bits appear on `sdio_o` with `sdio_oe_o` high for the whole transfer, and `sdo_oe_o` stays low.
- R7: With the pin-select input at 1, bits appear on `sdo_o` with `sdo_oe_o` high for the whole transfer, and `sdio_oe_o` stays low.
- R8: The 4-bit address wraps modulo 16 in both directions, so 15 is followed by 0 going up and 0 is followed by 15 going down.
- R9: The data bit on the active pin changes only at a falling edge of `sclk_o`. It holds steady while `sclk_o` is high, and every bit is valid at the rising edge where it is sampled.
- R10: For a count of N bytes, `busy_o` is high for exactly 16·N·HALF_PER system clock cycles. It drops at the last falling edge of `sclk_o`, and both output enables drop in the same cycle.
- R11: A start strobe is ignored while a transfer is running, and a start strobe with a count of 0 starts nothing.
- R12: The byte-order, bit-order and pin-select inputs are captured at the accepted start strobe. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a read transfer |
| start_addr_i | input | ADDR_W | First register address of the transfer |
| byte_cnt_i | input | CNT_W | Number of bytes to send; 0 is ignored |
| byte_down_i | input | 1 | Byte order: 0 steps the address up, 1 steps it down |
| bit_lsb_i | input | 1 | Bit order: 0 sends MSB first, 1 sends LSB first |
| pin_ded_i | input | 1 | Pin select: 0 uses the shared pin, 1 uses the dedicated pin |
| rf_addr_o | output | ADDR_W | Register-file read address |
| rf_data_i | input | DATA_W | Register-file read data, combinational from `rf_addr_o` |
| sclk_o | output | 1 | Serial clock; idles low |
| sdio_o | output | 1 | Shared bidirectional pin, output value |
| sdio_oe_o | output | 1 | Shared pin output enable |
| sdo_o | output | 1 | Dedicated pin, output value |
| sdo_oe_o | output | 1 | Dedicated pin output enable |
| busy_o | output | 1 | High while a transfer is running |

## Verification
The bench builds the engine with HALF_PER=2, which gives four system cycles per serial bit and leaves a full cycle where `sclk_o` is high and the data must hold. That exposes any bit change away from the falling edge.

The default CNT_W=4 allows a 15-byte read. Such a read crosses the top or bottom of the 4-bit address space in either direction, so the wrap is exercised along with longer transfers. The bench also checks the exact busy length for each byte count, and it exercises starts that arrive mid-transfer together with control inputs that flip during a transfer.

// File: rtl/srr_pkg.sv
package srr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } srr_state_e;

    // Transfer controls captured when a read is accepted
    typedef struct packed {
        logic byte_down;
        logic bit_lsb;
        logic pin_ded;
    } srr_cfg_t;

endpackage

// File: rtl/srr_sclk_gen.sv
// Divides the system clock into the serial clock; reports the falling edge.
module srr_sclk_gen #(
    parameter int HALF_PER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o
);
    localparam int TMR_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HALF_PER - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             sclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick_w;

    always_comb begin
        gen_d  = gen_q;
        tick_w = run_i && (gen_q.tmr == TMR_LAST);
        if (!run_i) begin
            gen_d.tmr  = '0;
            gen_d.sclk = 1'b0;
        end else if (tick_w) begin
            gen_d.tmr  = '0;
            gen_d.sclk = ~gen_q.sclk;
        end else begin
            gen_d.tmr = gen_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk_o = gen_q.sclk;
    assign fall_o = tick_w & gen_q.sclk;

endmodule

// File: rtl/srr_byte_shift.sv
// Holds the byte in flight and presents its current bit in either order.
module srr_byte_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    input  logic              lsb_first_i,
    output logic              bit_o,
    output logic              last_bit_o
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.sh  = load_data_i;
            shf_d.idx = '0;
        end else if (shift_i) begin
            shf_d.idx = shf_q.idx + 1'b1;
            if (lsb_first_i) begin
                shf_d.sh = {1'b0, shf_q.sh[DATA_W-1:1]};
            end else begin
                shf_d.sh = {shf_q.sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign bit_o      = lsb_first_i ? shf_q.sh[0] : shf_q.sh[DATA_W-1];
    assign last_bit_o = (shf_q.idx == IDX_LAST);

endmodule

// File: rtl/srr_addr_seq.sv
// Tracks the current address and the bytes left; steps up or down with wrap.
module srr_addr_seq #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              step_i,
    input  logic              down_i,
    output logic [ADDR_W-1:0] addr_next_o,
    output logic              last_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [ADDR_W-1:0] nxt_w;

    always_comb begin
        nxt_w = down_i ? (seq_q.addr - 1'b1) : (seq_q.addr + 1'b1);
        seq_d = seq_q;
        if (load_i) begin
            seq_d.addr = addr_i;
            seq_d.left = cnt_i;
        end else if (step_i) begin
            seq_d.addr = nxt_w;
            seq_d.left = seq_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_next_o = nxt_w;
    assign last_o      = (seq_q.left == CNT_W'(1));

endmodule

// File: rtl/serial_reg_reader.sv
module serial_reg_reader
    import srr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int HALF_PER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              byte_down_i,
    input  logic              bit_lsb_i,
    input  logic              pin_ded_i,
    output logic [ADDR_W-1:0] rf_addr_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              sclk_o,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              busy_o
);
    typedef struct packed {
        srr_state_e state;
        srr_cfg_t   cfg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic busy_w, go_w, fall_w, last_bit_w, last_byte_w;
    logic next_byte_w, sh_load_w, sh_shift_w, bit_w;
    logic [ADDR_W-1:0] addr_next_w;
    logic dir_down;

    always_comb begin
        ctl_d       = ctl_q;
        busy_w      = (ctl_q.state == ST_SHIFT);
        go_w        = !busy_w && start_i && (byte_cnt_i != '0);
        next_byte_w = busy_w && fall_w && last_bit_w && !last_byte_w;
        sh_load_w   = go_w || next_byte_w;
        sh_shift_w  = busy_w && fall_w && !last_bit_w;
        if (go_w) begin
            ctl_d.state = ST_SHIFT;
            ctl_d.cfg   = '{byte_down: byte_down_i, bit_lsb: bit_lsb_i, pin_ded: pin_ded_i};
        end else if (busy_w && fall_w && last_bit_w && last_byte_w) begin
            ctl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cfg: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    srr_sclk_gen #(.HALF_PER(HALF_PER)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_w),
        .sclk_o (sclk_o),
        .fall_o (fall_w)
    );

    srr_byte_shift #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load_w),
        .load_data_i (rf_data_i),
        .shift_i     (sh_shift_w),
        .lsb_first_i (go_w ? bit_lsb_i : ctl_q.cfg.bit_lsb),
        .bit_o       (bit_w),
        .last_bit_o  (last_bit_w)
    );

    srr_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (go_w),
        .addr_i      (start_addr_i),
        .cnt_i       (byte_cnt_i),
        .step_i      (next_byte_w),
        .down_i      (ctl_q.cfg.byte_down),
        .addr_next_o (addr_next_w),
        .last_o      (last_byte_w)
    );

    // Idle: present the start address; running: present the next byte's address
    assign rf_addr_o = busy_w ? addr_next_w : start_addr_i;
    assign dir_down  = ctl_q.cfg.byte_down;

    assign busy_o    = busy_w;
    assign sdio_oe_o = busy_w && !ctl_q.cfg.pin_ded;
    assign sdo_oe_o  = busy_w &&  ctl_q.cfg.pin_ded;
    assign sdio_o    = sdio_oe_o && bit_w;
    assign sdo_o     = sdo_oe_o && bit_w;

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              sclk_o,
    input logic              sdio_o,
    input logic              sdio_oe_o,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [ADDR_W-1:0] rf_addr_o,
    input logic              dir_down
);
    localparam logic [ADDR_W-1:0] STEP_UP   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_DOWN = {ADDR_W{1'b1}};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sdio_oe_o && !sdo_oe_o)); // R1

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones({sdio_oe_o, sdo_oe_o}) == 1)); // R6

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> ($stable(sdio_o) && $stable(sdo_o))); // R9

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (rf_addr_o != $past(rf_addr_o)))
        |-> (rf_addr_o == ($past(rf_addr_o) + (dir_down ? STEP_DOWN : STEP_UP)))); // R8

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R11

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(sclk_o) && !sdio_oe_o && !sdo_oe_o)); // R10

endmodule

bind serial_reg_reader srr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .sclk_o    (sclk_o),
    .sdio_o    (sdio_o),
    .sdio_oe_o (sdio_oe_o),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .rf_addr_o (rf_addr_o),
    .dir_down  (dir_down)
);

// File: tb/serial_reg_reader_tb.sv
module serial_reg_reader_tb;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [3:0] start_addr_i;
    logic [3:0] byte_cnt_i;
    logic       byte_down_i, bit_lsb_i, pin_ded_i;
    logic [3:0] rf_addr_o;
    logic [7:0] rf_data_i;
    logic       sclk_o, sdio_o, sdio_oe_o, sdo_o, sdo_oe_o, busy_o;

    logic [7:0] rf_mem [16];
    assign rf_data_i = rf_mem[rf_addr_o];

    always #2 clk = ~clk;   // 250 MHz

    serial_reg_reader #(.ADDR_W(4), .DATA_W(8), .CNT_W(4), .HALF_PER(HALF)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .byte_cnt_i   (byte_cnt_i),
        .byte_down_i  (byte_down_i),
        .bit_lsb_i    (bit_lsb_i),
        .pin_ded_i    (pin_ded_i),
        .rf_addr_o    (rf_addr_o),
        .rf_data_i    (rf_data_i),
        .sclk_o       (sclk_o),
        .sdio_o       (sdio_o),
        .sdio_oe_o    (sdio_oe_o),
        .sdo_o        (sdo_o),
        .sdo_oe_o     (sdo_oe_o),
        .busy_o       (busy_o)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    exp_q[$];
    bit    cur_pin = 1'b0;
    string cur_tag = "R2";
    bit    sclk_prev = 1'b0;
    bit    held = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares each bit at the rising serial edge against the scoreboard
    always @(negedge clk) begin
        bit got;
        bit e;
        if (rst_n && !done) begin
            got = cur_pin ? sdo_o : sdio_o;
            if (sclk_o && !sclk_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected bit"}, 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, cur_tag, int'(got), int'(e));
                    chk(cur_pin ? (sdo_oe_o && !sdio_oe_o) : (sdio_oe_o && !sdo_oe_o),
                        cur_pin ? "R7 pin enables" : "R6 pin enables",
                        int'({sdio_oe_o, sdo_oe_o}), cur_pin ? 1 : 2);
                    held = got;
                end
            end else if (sclk_o && sclk_prev) begin
                chk(got == held, "R9 hold while high", int'(got), int'(held));
            end
            sclk_prev = sclk_o;
        end
    end

    // Driver: pushes the expected bit stream, then launches the transfer
    task automatic run_xfer(input logic [3:0] a0, input int n, input bit bdown,
                            input bit blsb, input bit pded, input string tag,
                            input bit disturb);
        int nb;
        cur_pin = pded;
        cur_tag = tag;
        for (int k = 0; k < n; k++) begin
            logic [3:0] a;
            a = bdown ? (a0 - 4'(k)) : (a0 + 4'(k));
            for (int j = 0; j < 8; j++) begin
                exp_q.push_back(blsb ? rf_mem[a][j] : rf_mem[a][7-j]);
            end
        end
        @(negedge clk);
        start_addr_i = a0;
        byte_cnt_i   = 4'(n);
        byte_down_i  = bdown;
        bit_lsb_i    = blsb;
        pin_ded_i    = pded;
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        nb = 0;
        while (busy_o && nb < 4000) begin
            nb++;
            if (disturb && nb == 20) begin
                start_i      = 1'b1;
                start_addr_i = a0 + 4'd3;
                byte_cnt_i   = 4'd1;
                byte_down_i  = ~bdown;
                bit_lsb_i    = ~blsb;
                pin_ded_i    = ~pded;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(nb == 16 * n * HALF, "R10 busy length", nb, 16 * n * HALF);
        chk(exp_q.size() == 0, {tag, " bits left"}, exp_q.size(), 0);
        chk(!sdio_oe_o && !sdo_oe_o, "R10 enables released",
            int'({sdio_oe_o, sdo_oe_o}), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf_mem[i] = 8'(8'h5A ^ (i * 37));
        end
        rst_n        = 1'b0;
        start_i      = 1'b0;
        start_addr_i = '0;
        byte_cnt_i   = '0;
        byte_down_i  = 1'b0;
        bit_lsb_i    = 1'b0;
        pin_ded_i    = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !sclk_o && !sdio_oe_o && !sdo_oe_o, "R1 reset state",
            int'({busy_o, sclk_o, sdio_oe_o, sdo_oe_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !sclk_o && !sdio_oe_o && !sdo_oe_o, "R1 idle after reset",
            int'({busy_o, sclk_o, sdio_oe_o, sdo_oe_o}), 0);

        run_xfer(4'd2,  3, 1'b0, 1'b0, 1'b0, "R2 R4 R6 up msb shared", 1'b0);
        run_xfer(4'd9,  4, 1'b1, 1'b0, 1'b1, "R3 R7 down msb dedicated", 1'b0);
        run_xfer(4'd5,  2, 1'b0, 1'b1, 1'b0, "R5 lsb first", 1'b0);
        run_xfer(4'd14, 4, 1'b0, 1'b0, 1'b0, "R8 wrap upward", 1'b0);
        run_xfer(4'd1,  3, 1'b1, 1'b1, 1'b1, "R8 wrap downward", 1'b0);

        // R11: zero count starts nothing
        @(negedge clk);
        start_addr_i = 4'd4;
        byte_cnt_i   = 4'd0;
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy_o && !sdio_oe_o && !sdo_oe_o && !sclk_o, "R11 zero count",
            int'({busy_o, sclk_o, sdio_oe_o, sdo_oe_o}), 0);

        run_xfer(4'd7,  2, 1'b0, 1'b0, 1'b0, "R11 R12 inputs moved mid transfer", 1'b1);
        run_xfer(4'd3,  2, 1'b1, 1'b1, 1'b1, "R12 inputs moved mid transfer", 1'b1);
        run_xfer(4'd0, 15, 1'b1, 1'b0, 1'b1, "R3 R8 full count down", 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule